// File: doc/BRIEF.md
# Dual-Width Condition Code Generator

This block computes the next value of an 8-bit condition code register from the operands and result of one arithmetic operation. It produces the negative, zero, overflow and carry flags for add, subtract, test and shift operations on 8-bit or 16-bit data. These four flags are merged into the incoming register value, so the interrupt-mask, half-carry, extra-mask and stop bits pass through unchanged.

The unit is purely combinational and sits beside an ALU. The ALU supplies both operands, its result, the shifted-out bit for shifts, a width select and an operation class. The block returns the register value to be written back in the same cycle. Carry and overflow come from sign-bit equations over the operands and the result. The block does not need a carry chain from the ALU.

Top module: `cc_gen`

## Requirements
- R1: Register bit positions are C=0, V=1, Z=2, N=3, I=4, H=5, X=6, S=7; bits 7:4 of `ccr_o` always equal bits 7:4 of `ccr_i`.
- R2: N is bit 7 of the result when `wide_i`=0 and bit 15 when `wide_i`=1.
- R3: Z is 1 exactly when the result at the selected width is all zeros.
- R4: For add (`op_i`=00), C is the sign bit of (a&b)|(b&~r)|(a&~r), i.e. the carry out of a+b.
- R5: For add, V is the sign bit of (a&b&~r)|(~a&~b&r), i.e. signed overflow of a+b.
- R6: For subtract (`op_i`=01), C is the sign bit of (~a&b)|(b&r)|(~a&r), i.e. the borrow of a-b.
- R7: For subtract, V is the sign bit of (a&~b&~r)|(~a&b&r), i.e. signed overflow of a-b.
- R8: For test (`op_i`=10), V is cleared and C keeps its value from `ccr_i`.
- R9: For shift (`op_i`=11), C takes `shc_i` and V equals the new N XOR the new C.
- R10: With `wide_i`=0, bits 15:8 of `a_i`, `b_i` and `r_i` have no effect on `ccr_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| r_i | input | 16 | ALU result |
| wide_i | input | 1 | 0 = 8-bit, 1 = 16-bit |
| op_i | input | 2 | 00 add, 01 subtract, 10 test, 11 shift |
| shc_i | input | 1 | Bit shifted out, new carry for shifts |
| ccr_i | input | 8 | Current condition code register |
| ccr_o | output | 8 | Next condition code register |

## Verification
The bench targets the sign-boundary crossings 0x7F+1 and 0x80-1, and their 16-bit equivalents. A design that swapped the add and subtract equations, or took the sign from the wrong byte, would report false overflow there. Results that wrap to zero check that Z and C are set together. In narrow mode, garbage in the upper bytes catches a Z or N that reads bits outside the selected width. Test and shift cases start with C and V both set and both clear. This exposes a design that clears C on a test or derives V from the old carry instead of the new one.

// File: rtl/cc_gen_pkg.sv
package cc_gen_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_TST = 2'b10,
    OP_SHF = 2'b11
  } cc_op_e;

  localparam int unsigned BIT_C = 0;
  localparam int unsigned BIT_V = 1;
  localparam int unsigned BIT_Z = 2;
  localparam int unsigned BIT_N = 3;

  typedef struct packed {
    logic n;
    logic z;
    logic c_add;
    logic v_add;
    logic c_sub;
    logic v_sub;
  } flag_set_t;
endpackage

// File: rtl/cc_flag_eval.sv
module cc_flag_eval
  import cc_gen_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] r_i,
  output flag_set_t    flags_o
);
  localparam int unsigned MSB = W - 1;

  logic [W-1:0] c_add_v, v_add_v, c_sub_v, v_sub_v;

  assign c_add_v = (a_i & b_i) | (b_i & ~r_i) | (a_i & ~r_i);
  assign v_add_v = (a_i & b_i & ~r_i) | (~a_i & ~b_i & r_i);
  assign c_sub_v = (~a_i & b_i) | (b_i & r_i) | (~a_i & r_i);
  assign v_sub_v = (a_i & ~b_i & ~r_i) | (~a_i & b_i & r_i);

  assign flags_o.n     = r_i[MSB];
  assign flags_o.z     = ~|r_i;
  assign flags_o.c_add = c_add_v[MSB];
  assign flags_o.v_add = v_add_v[MSB];
  assign flags_o.c_sub = c_sub_v[MSB];
  assign flags_o.v_sub = v_sub_v[MSB];
endmodule

// File: rtl/cc_merge.sv
module cc_merge
  import cc_gen_pkg::*;
#(
  parameter int unsigned CCR_W = 8
) (
  input  cc_op_e           op_i,
  input  logic             shc_i,
  input  flag_set_t        flags_i,
  input  logic [CCR_W-1:0] ccr_i,
  output logic [CCR_W-1:0] ccr_o
);
  always_comb begin
    ccr_o        = ccr_i;
    ccr_o[BIT_N] = flags_i.n;
    ccr_o[BIT_Z] = flags_i.z;
    unique case (op_i)
      OP_ADD: begin
        ccr_o[BIT_C] = flags_i.c_add;
        ccr_o[BIT_V] = flags_i.v_add;
      end
      OP_SUB: begin
        ccr_o[BIT_C] = flags_i.c_sub;
        ccr_o[BIT_V] = flags_i.v_sub;
      end
      OP_TST: ccr_o[BIT_V] = 1'b0;
      OP_SHF: begin
        ccr_o[BIT_C] = shc_i;
        ccr_o[BIT_V] = flags_i.n ^ shc_i;
      end
      default: ccr_o = ccr_i;
    endcase
  end
endmodule

// File: rtl/cc_gen.sv
module cc_gen
  import cc_gen_pkg::*;
#(
  parameter int unsigned NARROW_W = 8,
  parameter int unsigned WIDE_W   = 16,
  parameter int unsigned CCR_W    = 8
) (
  input  logic [WIDE_W-1:0] a_i,
  input  logic [WIDE_W-1:0] b_i,
  input  logic [WIDE_W-1:0] r_i,
  input  logic              wide_i,
  input  logic [1:0]        op_i,
  input  logic              shc_i,
  input  logic [CCR_W-1:0]  ccr_i,
  output logic [CCR_W-1:0]  ccr_o
);
  localparam int unsigned NUM_W = 2;

  flag_set_t fs [NUM_W];
  flag_set_t fsel;

  for (genvar g = 0; g < NUM_W; g++) begin : g_width
    localparam int unsigned GW = (g == 0) ? NARROW_W : WIDE_W;
    cc_flag_eval #(.W(GW)) u_eval (
      .a_i     (a_i[GW-1:0]),
      .b_i     (b_i[GW-1:0]),
      .r_i     (r_i[GW-1:0]),
      .flags_o (fs[g])
    );
  end

  assign fsel = wide_i ? fs[1] : fs[0];

  cc_merge #(.CCR_W(CCR_W)) u_merge (
    .op_i    (cc_op_e'(op_i)),
    .shc_i   (shc_i),
    .flags_i (fsel),
    .ccr_i   (ccr_i),
    .ccr_o   (ccr_o)
  );
endmodule

// File: rtl/cc_gen_chk.sv
module cc_gen_chk #(
  parameter int unsigned NARROW_W = 8,
  parameter int unsigned WIDE_W   = 16,
  parameter int unsigned CCR_W    = 8
) (
  input logic [WIDE_W-1:0] a_i,
  input logic [WIDE_W-1:0] b_i,
  input logic [WIDE_W-1:0] r_i,
  input logic              wide_i,
  input logic [1:0]        op_i,
  input logic              shc_i,
  input logic [CCR_W-1:0]  ccr_i,
  input logic [CCR_W-1:0]  ccr_o
);
  logic known;
  assign known = !$isunknown({a_i, b_i, r_i, wide_i, op_i, shc_i, ccr_i});

  always_comb begin
    if (known) begin
      AST_UPPER_KEEP: assert (ccr_o[7:4] == ccr_i[7:4]); // R1
      AST_Z_CLEARS_N: assert (!(ccr_o[2] && ccr_o[3])); // R3
      if (op_i == 2'b10) begin
        AST_TST_V_CLEAR: assert (ccr_o[1] == 1'b0 && ccr_o[0] == ccr_i[0]); // R8
      end
      if (op_i == 2'b11) begin
        AST_SHF_V_XOR: assert (ccr_o[1] == (ccr_o[3] ^ ccr_o[0]) && ccr_o[0] == shc_i); // R9
      end
      if (!wide_i) begin
        AST_NARROW_N: assert (ccr_o[3] == r_i[NARROW_W-1]); // R2
      end
    end
  end
endmodule

bind cc_gen cc_gen_chk #(.NARROW_W(NARROW_W), .WIDE_W(WIDE_W), .CCR_W(CCR_W)) chk_i (.*);

// File: tb/cc_gen_tb_top.sv
module cc_gen_tb_top;
  logic        clk = 1'b0;
  logic [15:0] a, b, r;
  logic        wide, shc;
  logic [1:0]  op;
  logic [7:0]  ccr_in, ccr_out;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  typedef struct {
    logic [7:0] exp;
    string      req;
  } item_t;
  item_t q[$];

  always #10 clk = ~clk;

  cc_gen dut_i (
    .a_i(a), .b_i(b), .r_i(r), .wide_i(wide), .op_i(op),
    .shc_i(shc), .ccr_i(ccr_in), .ccr_o(ccr_out)
  );

  function automatic logic [7:0] model(input logic [15:0] fa, fb, fr, input logic fw,
                                       input logic [1:0] fop, input logic fsh,
                                       input logic [7:0] fc);
    logic [15:0] am, bm, rm;
    logic [16:0] sum;
    int msb;
    logic n, z, c, v;
    msb = fw ? 15 : 7;
    am = fw ? fa : {8'h00, fa[7:0]};
    bm = fw ? fb : {8'h00, fb[7:0]};
    rm = fw ? fr : {8'h00, fr[7:0]};
    n = rm[msb];
    z = (rm == 16'h0);
    c = fc[0];
    v = fc[1];
    case (fop)
      2'b00: begin
        sum = {1'b0, am} + {1'b0, bm};
        c = sum[msb+1];
        v = (am[msb] == bm[msb]) && (rm[msb] != am[msb]);
      end
      2'b01: begin
        c = am < bm;
        v = (am[msb] != bm[msb]) && (rm[msb] != am[msb]);
      end
      2'b10: v = 1'b0;
      default: begin
        c = fsh;
        v = n ^ fsh;
      end
    endcase
    return {fc[7:4], n, z, v, c};
  endfunction

  task automatic drive(input logic [15:0] ta, tb, tr, input logic tw, input logic [1:0] top,
                       input logic tsh, input logic [7:0] tc, input string req);
    item_t it;
    @(posedge clk);
    #1;
    a = ta; b = tb; r = tr; wide = tw; op = top; shc = tsh; ccr_in = tc;
    it.exp = model(ta, tb, tr, tw, top, tsh, tc);
    it.req = req;
    q.push_back(it);
  endtask

  task automatic do_add(input logic [15:0] ta, tb, input logic tw, input logic [7:0] tc, input string req);
    drive(ta, tb, ta + tb, tw, 2'b00, 1'b0, tc, req);
  endtask

  task automatic do_sub(input logic [15:0] ta, tb, input logic tw, input logic [7:0] tc, input string req);
    drive(ta, tb, ta - tb, tw, 2'b01, 1'b0, tc, req);
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      n_run++;
      if (ccr_out !== it.exp) begin
        n_fail++;
        $display("FAIL %s: ccr_o=%02h expected %02h", it.req, ccr_out, it.exp);
      end
    end
  end

  initial begin
    a = '0; b = '0; r = '0; wide = 1'b0; op = 2'b00; shc = 1'b0; ccr_in = '0;
    drive(16'h0, 16'h0, 16'h0, 1'b0, 2'b00, 1'b0, 8'h00, "R3 zero inputs");
    do_add(16'h007F, 16'h0001, 1'b0, 8'h00, "R5 narrow add overflow");
    do_add(16'h00FF, 16'h0001, 1'b0, 8'h00, "R4 narrow add carry to zero");
    do_add(16'h8000, 16'h8000, 1'b1, 8'h00, "R4 R5 wide add wrap");
    do_add(16'h1234, 16'h0001, 1'b1, 8'hFF, "R4 wide add no carry");
    do_add(16'h7FFF, 16'h0001, 1'b1, 8'h00, "R5 wide add overflow");
    do_sub(16'h0000, 16'h0001, 1'b0, 8'h00, "R6 narrow borrow");
    do_sub(16'h0080, 16'h0001, 1'b0, 8'h00, "R7 narrow sub overflow");
    do_sub(16'h8000, 16'h0001, 1'b1, 8'h00, "R7 wide sub overflow");
    do_sub(16'h0005, 16'h0005, 1'b1, 8'h03, "R6 R3 wide sub zero");
    do_sub(16'h0001, 16'h8000, 1'b1, 8'h00, "R6 wide borrow");
    drive(16'h0, 16'h0, 16'h0080, 1'b0, 2'b10, 1'b0, 8'h03, "R8 test keeps C clears V");
    drive(16'h0, 16'h0, 16'h0001, 1'b1, 2'b10, 1'b1, 8'h00, "R8 test C stays 0");
    drive(16'h0, 16'h0, 16'h0000, 1'b0, 2'b11, 1'b1, 8'h00, "R9 shift C=1 N=0");
    drive(16'h0, 16'h0, 16'h0080, 1'b0, 2'b11, 1'b0, 8'h03, "R9 shift C=0 N=1");
    drive(16'h0, 16'h0, 16'h8000, 1'b1, 2'b11, 1'b1, 8'h02, "R9 wide shift N=1 C=1");
    drive(16'hAB01, 16'hCDFF, 16'h1200, 1'b0, 2'b00, 1'b0, 8'h00, "R10 narrow ignores upper");
    drive(16'hFF00, 16'h7F00, 16'h8001, 1'b0, 2'b10, 1'b0, 8'h00, "R10 narrow test upper");
    drive(16'h0, 16'h0, 16'h0080, 1'b1, 2'b10, 1'b0, 8'h00, "R2 wide N from bit 15");
    drive(16'h0, 16'h0, 16'h8000, 1'b0, 2'b10, 1'b0, 8'h00, "R2 narrow N from bit 7");
    drive(16'h0, 16'h0, 16'h0000, 1'b0, 2'b11, 1'b0, 8'hF0, "R1 upper bits kept");
    drive(16'h0012, 16'h0034, 16'h0046, 1'b0, 2'b00, 1'b0, 8'hA5, "R1 pattern kept on add");
    for (int i = 0; i < 16; i++) begin
      do_add(16'(i * 16'h1111), 16'(16'hF00F - i * 16'h0301), i[0], 8'(i * 16), "R4 R5 sweep add");
      do_sub(16'(i * 16'h0907), 16'(16'h7777 + i * 16'h1003), i[1], 8'(i * 16 + 5), "R6 R7 sweep sub");
    end
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule